// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block turns one digital clock into the four gate commands of a full-bridge power stage. A free-running tick counter sets the switching cycle. The first leg (outputs A and B) swaps its active side at the start of every cycle, so each of its outputs runs at half the cycle rate with close to 50% duty. The second leg (outputs C and D) copies the first leg's polarity a programmable number of ticks later. The transformer sees voltage only while the two legs disagree, so that delay sets the delivered power. A cycle-by-cycle current-limit flag can end the delay early.

Each leg inserts its own break-before-make gap between its two complementary outputs. The gap comes from a per-leg base word. It can be shrunk at heavy load: a delay level is formed from the difference between a digitized current-sense code and an adaptive-set code, and the base is scaled by the ratio of the no-load level to that delay level. At the peak-current point with the adaptive-set code at zero, the gap shrinks to a quarter of its base. The phase command, the two gaps and the adaptive scaling are all captured at each cycle start, so an input change during a cycle cannot leave a runt pulse.

Top module: `psfb_modulator`

## Requirements
- R1: While enabled, `cycle_start` pulses for one clock every PERIOD clocks. Leg A/B swaps sides at every cycle start, so `out_a` and `out_b` are each high for PERIOD − (gap + 1) clocks out of every 2·PERIOD.
- R2: Leg C/D takes the A/B polarity PH ticks after the cycle start, where PH is `phase_cmd` captured at that start, and any value above PERIOD−1 acts as PERIOD−1. The clock count from a rise of `out_a` to the next rise of `out_c` is PH + gapCD − gapAB.
- R3: The two outputs of one leg are never high together. After every swap, both stay low for exactly gap + 1 clocks before the newly active output rises.
- R4: Codes are in 1/64 V units. V = 32 + floor(3·max(`isense` − `adapt_set`, 0)/4), clamped to at most 128. The gap of a leg is floor(base·32 / V), with base `dead_ab` or `dead_cd`.
- R5: When `adapt_set` ≥ `isense`, the gap equals the base (no modulation). When `isense` − `adapt_set` ≥ 128, the gap is floor(base/4).
- R6: `ilim` high at a tick of the cycle before the phase tick makes leg C/D swap at that tick. Leg C/D swaps at most once per cycle. With `ilim` held high, it swaps at the cycle start.
- R7: A base of 0 defeats the programmed gap, leaving a fixed 1-clock gap.
- R8: A change of `phase_cmd` after a cycle start has no effect until the next cycle start.
- R9: During reset and while `en` is low, all four outputs and `cycle_start` are low. After `en` rises, `out_a` rises first, gapAB + 2 clocks later, and `out_b` stays low until then.
- R10: The two legs use independent base words and have independent gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks all outputs low |
| phase_cmd | input | CNT_W | Leg C/D delay in ticks |
| ilim | input | 1 | Cycle-by-cycle current-limit flag |
| dead_ab | input | DT_W | Base gap of leg A/B in ticks |
| dead_cd | input | DT_W | Base gap of leg C/D in ticks |
| isense | input | CS_W | Current-sense code, 1/64 V per LSB |
| adapt_set | input | CS_W | Adaptive-set code, 1/64 V per LSB |
| out_a | output | 1 | Leg A/B, side A |
| out_b | output | 1 | Leg A/B, side B |
| out_c | output | 1 | Leg C/D, side C |
| out_d | output | 1 | Leg C/D, side D |
| cycle_start | output | 1 | One-clock strobe at each cycle start |

## Verification
The assertions assume that the scaled gap of each leg stays well below PERIOD, so every leg reaches its on state before its next swap. They also assume that `ilim` is a clean synchronous level. The stimulus keeps the bases at 10 ticks or less against a 60-tick cycle. It drives every input only on falling clock edges. It pulses `ilim` inside a side-A cycle, at a tick counted from the observed `cycle_start`. For phase measurements, gapCD is kept at least as large as gapAB whenever the commanded phase is small, so each rise of `out_c` follows the rise of `out_a` it is measured against.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

   // Delay level at zero load and its upper clamp, in 1/64 V steps.
   localparam int unsigned VDEL_ZERO = 32;
   localparam int unsigned VDEL_CEIL = 128;

   // Break-before-make sequencer state of one leg.
   typedef enum logic [1:0] {
      LEG_IDLE = 2'd0,
      LEG_GAP  = 2'd1,
      LEG_ON   = 2'd2
   } leg_state_e;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
   parameter int PERIOD = 60,
   parameter int CNT_W  = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] phase_cmd,
   input  logic             ilim,
   output logic             start,
   output logic             strobe,
   output logic             ab_ref,
   output logic             cd_ref
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] ph_l;
   logic [CNT_W-1:0] ph_in;
   logic [CNT_W-1:0] ph_eff;
   logic             done;
   logic             done_eff;
   logic             fire;
   logic             ab_next;

   // Command clamp and the values that hold inside the current tick
   always_comb begin
      start    = en && (cnt == '0);
      ph_in    = (phase_cmd > LAST) ? LAST : phase_cmd;
      ph_eff   = start ? ph_in : ph_l;
      done_eff = start ? 1'b0 : done;
      fire     = en && !done_eff && (ilim || (cnt == ph_eff));
      ab_next  = start ? ~ab_ref : ab_ref;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         ph_l   <= '0;
         done   <= 1'b0;
         strobe <= 1'b0;
         ab_ref <= 1'b0;
         cd_ref <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         ph_l   <= '0;
         done   <= 1'b0;
         strobe <= 1'b0;
         ab_ref <= 1'b0;
         cd_ref <= 1'b0;
      end else begin
         cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
         strobe <= start;
         ab_ref <= ab_next;
         done   <= done_eff | fire;
         if (start) ph_l <= ph_in;
         if (fire)  cd_ref <= ab_next;
      end
   end

   // R1: the strobe is one clock wide
   assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R1: leg A/B swaps only on a cycle start
   assert_ab_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !start) |=> $stable(ab_ref));

   // R6: leg C/D swaps at most once inside one cycle
   assert_cd_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && en) |=> (!fire || start));

   // R9: disabled timebase parks both references low
   assert_idle_refs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!ab_ref && !cd_ref && !strobe));

endmodule

// File: rtl/psfb_dt_scale.sv
module psfb_dt_scale
   import psfb_pkg::*;
#(
   parameter int DT_W     = 8,
   parameter int CS_W     = 8,
   parameter bit ADAPT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            load,
   input  logic [DT_W-1:0] base,
   input  logic [CS_W-1:0] sense,
   input  logic [CS_W-1:0] adapt,
   output logic [DT_W-1:0] dt
);

   localparam int NUM_W = DT_W + 5;
   localparam int VW    = CS_W + 3;

   logic [DT_W-1:0] dt_next;

   generate
      if (ADAPT_EN) begin : g_adapt
         logic [CS_W-1:0]   diff;
         logic [CS_W+1:0]   tri_d;
         logic [VW-1:0]     vsum;
         logic [7:0]        vdel;
         logic [NUM_W-1:0]  num;

         always_comb begin
            diff    = (sense > adapt) ? (sense - adapt) : '0;
            tri_d   = {1'b0, diff, 1'b0} + {2'b00, diff};
            vsum    = VW'(tri_d >> 2) + VW'(VDEL_ZERO);
            vdel    = (vsum > VW'(VDEL_CEIL)) ? 8'(VDEL_CEIL) : vsum[7:0];
            num     = {base, 5'b00000};
            dt_next = DT_W'(num / {{(NUM_W-8){1'b0}}, vdel});
         end

         // R4: scaling never lengthens the gap beyond its base
         assert_dt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (load && en) |=> (dt <= $past(base)));

         // R5: no modulation while adapt-set is at or above current sense
         assert_no_modulation_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (load && en && (adapt >= sense)) |=> (dt == $past(base)));
      end else begin : g_fixed
         assign dt_next = base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dt <= '0;
      else if (!en)    dt <= '0;
      else if (load)   dt <= dt_next;
   end

endmodule

// File: rtl/psfb_leg_drive.sv
module psfb_leg_drive
   import psfb_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            ref_in,
   input  logic [DT_W-1:0] dt,
   output logic            hi,
   output logic            lo
);

   leg_state_e      state;
   logic            r_q;
   logic [DT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LEG_IDLE;
         r_q   <= 1'b0;
         cnt   <= '0;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (!en) begin
         state <= LEG_IDLE;
         r_q   <= 1'b0;
         cnt   <= '0;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (state == LEG_IDLE) begin
         // wait for the first active-high request before driving anything
         if (ref_in) begin
            r_q   <= 1'b1;
            cnt   <= dt;
            state <= LEG_GAP;
         end
      end else if (ref_in != r_q) begin
         r_q   <= ref_in;
         cnt   <= dt;
         state <= LEG_GAP;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else if (state == LEG_GAP) begin
         if (cnt == '0) begin
            state <= LEG_ON;
            hi    <= r_q;
            lo    <= ~r_q;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R3: complementary pair never conducts together
   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi && lo));

   // R3: a side may not hand over directly to the other side
   assert_bbm_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hi |=> !lo);

   assert_bbm_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lo |=> !hi);

endmodule

// File: rtl/psfb_modulator.sv
module psfb_modulator #(
   parameter int PERIOD   = 60,
   parameter int DT_W     = 8,
   parameter int CS_W     = 8,
   parameter bit ADAPT_EN = 1'b1,
   localparam int CNT_W   = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] phase_cmd,
   input  logic             ilim,
   input  logic [DT_W-1:0]  dead_ab,
   input  logic [DT_W-1:0]  dead_cd,
   input  logic [CS_W-1:0]  isense,
   input  logic [CS_W-1:0]  adapt_set,
   output logic             out_a,
   output logic             out_b,
   output logic             out_c,
   output logic             out_d,
   output logic             cycle_start
);

   localparam int NLEG = 2;

   generate
      if (PERIOD < 4) begin : g_chk_period
         $error("PERIOD must be at least 4");
      end
      if (DT_W < 4) begin : g_chk_dt
         $error("DT_W must be at least 4");
      end
      if (CS_W < 6) begin : g_chk_cs
         $error("CS_W must be at least 6");
      end
   endgenerate

   logic            start;
   logic            leg_ref [NLEG];
   logic [DT_W-1:0] leg_base [NLEG];
   logic [DT_W-1:0] leg_dt   [NLEG];
   logic            leg_hi   [NLEG];
   logic            leg_lo   [NLEG];

   assign leg_base[0] = dead_ab;
   assign leg_base[1] = dead_cd;

   psfb_timebase #(
      .PERIOD (PERIOD),
      .CNT_W  (CNT_W)
   ) u_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .phase_cmd (phase_cmd),
      .ilim      (ilim),
      .start     (start),
      .strobe    (cycle_start),
      .ab_ref    (leg_ref[0]),
      .cd_ref    (leg_ref[1])
   );

   generate
      for (genvar i = 0; i < NLEG; i++) begin : g_leg
         psfb_dt_scale #(
            .DT_W     (DT_W),
            .CS_W     (CS_W),
            .ADAPT_EN (ADAPT_EN)
         ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .load  (start),
            .base  (leg_base[i]),
            .sense (isense),
            .adapt (adapt_set),
            .dt    (leg_dt[i])
         );

         psfb_leg_drive #(
            .DT_W (DT_W)
         ) u_drive (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .ref_in (leg_ref[i]),
            .dt     (leg_dt[i]),
            .hi     (leg_hi[i]),
            .lo     (leg_lo[i])
         );
      end
   endgenerate

   assign out_a = leg_hi[0];
   assign out_b = leg_lo[0];
   assign out_c = leg_hi[1];
   assign out_d = leg_lo[1];

   // R9: a disabled bridge goes quiet one clock later
   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!out_a && !out_b && !out_c && !out_d));

   // R2: leg C/D never swaps without leg A/B having been started
   assert_cd_after_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_a && !out_b && !en) |=> !out_c);

endmodule

// File: tb/psfb_modulator_tb.sv
module psfb_modulator_tb;

   localparam int PERIOD = 60;
   localparam int DT_W   = 8;
   localparam int CS_W   = 8;
   localparam int CNT_W  = $clog2(PERIOD);

   localparam int K_GAB = 0;
   localparam int K_GCD = 1;
   localparam int K_PH  = 2;

   typedef struct {
      int    kind;
      int    val;
      string tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b1;
   logic [CNT_W-1:0] phase_cmd = '0;
   logic             ilim = 1'b0;
   logic [DT_W-1:0]  dead_ab = 8'd8;
   logic [DT_W-1:0]  dead_cd = 8'd8;
   logic [CS_W-1:0]  isense = '0;
   logic [CS_W-1:0]  adapt_set = '0;
   logic             out_a, out_b, out_c, out_d, cycle_start;

   int compared = 0;
   int mismatched = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   psfb_modulator #(
      .PERIOD (PERIOD),
      .DT_W   (DT_W),
      .CS_W   (CS_W)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .phase_cmd   (phase_cmd),
      .ilim        (ilim),
      .dead_ab     (dead_ab),
      .dead_cd     (dead_cd),
      .isense      (isense),
      .adapt_set   (adapt_set),
      .out_a       (out_a),
      .out_b       (out_b),
      .out_c       (out_c),
      .out_d       (out_d),
      .cycle_start (cycle_start)
   );

   // Gap model taken from R4
   function automatic int gap_model(int base, int cs, int ads);
      int diff, v;
      diff = (cs > ads) ? cs - ads : 0;
      v = 32 + (3 * diff) / 4;
      if (v > 128) v = 128;
      return (base * 32) / v;
   endfunction

   task automatic check(string tag, int got, int expv);
      compared++;
      if (got != expv) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", tag, got, expv);
      end
   endtask

   // ---------------- monitor ----------------
   int  t_now = 0, t_a = 0, low_ab = 0, low_cd = 0;
   bit  pa = 0, pc = 0, overlap_seen = 0;

   task automatic observe(int kind, int val);
      exp_t e;
      if (exp_q.size() > 0 && exp_q[0].kind == kind) begin
         e = exp_q.pop_front();
         check(e.tag, val, e.val);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         t_now++;
         if ((out_a && out_b) || (out_c && out_d)) overlap_seen = 1;
         if (out_a && !pa) begin
            observe(K_GAB, low_ab);
            t_a = t_now;
         end
         if (out_c && !pc) begin
            observe(K_GCD, low_cd);
            observe(K_PH, t_now - t_a);
         end
         low_ab = (out_a || out_b) ? 0 : low_ab + 1;
         low_cd = (out_c || out_d) ? 0 : low_cd + 1;
         pa = out_a;
         pc = out_c;
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         mismatched++;
         compared++;
         $display("FAIL all: watchdog expired, got %0d cycles expected under 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   // ---------------- driver ----------------
   task automatic push(int kind, int val, string tag);
      exp_t e;
      e.kind = kind; e.val = val; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!cycle_start);
   endtask

   // negedge just after the start of a side-A cycle (B still driven)
   task automatic sync_a();
      do @(negedge clk); while (!(cycle_start && out_b));
   endtask

   task automatic settle();
      wait_strobe();
      wait_strobe();
   endtask

   task automatic drain();
      int n = 0;
      while (exp_q.size() > 0 && n < 600) begin
         @(negedge clk);
         n++;
      end
      if (exp_q.size() > 0) begin
         check({exp_q[0].tag, " event missing"}, -1, exp_q[0].val);
         exp_q.delete();
      end
   endtask

   task automatic leg_case(int gab, int gcd, int ph, string tg_ab, string tg_cd, string tg_ph);
      settle();
      sync_a();
      push(K_GAB, gab, tg_ab);
      push(K_GCD, gcd, tg_cd);
      push(K_PH, ph, tg_ph);
      drain();
   endtask

   initial begin
      int g, gc, n;
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 reset outputs", {out_a, out_b, out_c, out_d, cycle_start}, 0);
      rst_n = 1'b1;

      // R1: strobe spacing and side-A on-time
      phase_cmd = 6'd16;
      settle();
      wait_strobe();
      n = 0;
      do begin @(negedge clk); n++; end while (!cycle_start);
      check("R1 strobe period", n, PERIOD);
      sync_a();
      while (!out_a) @(negedge clk);
      n = 0;
      while (out_a) begin n++; @(negedge clk); end
      check("R1 side A on-time", n, PERIOD - (gap_model(8, 0, 0) + 1));

      // R3/R2: base gaps, nominal phase
      g = gap_model(8, 0, 0);
      leg_case(g + 1, g + 1, 16, "R3 gap AB base", "R3 gap CD base", "R2 phase 16");

      // R5: peak current, adapt-set zero -> quarter gap
      isense = 8'd128;
      g = gap_model(8, 128, 0);
      leg_case(g + 1, g + 1, 16, "R5 quarter gap AB", "R5 quarter gap CD", "R2 phase at peak load");

      // R4: mid-load scaling
      isense = 8'd64;
      g = gap_model(8, 64, 0);
      leg_case(g + 1, g + 1, 16, "R4 mid-load gap AB", "R4 mid-load gap CD", "R2 phase mid-load");

      // R4: clamp of the delay level
      isense = 8'd200;
      g = gap_model(8, 200, 0);
      leg_case(g + 1, g + 1, 16, "R4 clamp gap AB", "R4 clamp gap CD", "R2 phase clamp load");

      // R5: adapt-set equal to / above sense -> no modulation
      isense = 8'd100; adapt_set = 8'd100;
      leg_case(9, 9, 16, "R5 equal codes gap AB", "R5 equal codes gap CD", "R2 phase equal codes");
      isense = 8'd50; adapt_set = 8'd90;
      leg_case(9, 9, 16, "R5 adapt above gap AB", "R5 adapt above gap CD", "R2 phase adapt above");
      isense = 8'd0; adapt_set = 8'd0;

      // R7: defeated gap
      dead_ab = 8'd0; dead_cd = 8'd0;
      leg_case(1, 1, 16, "R7 defeated gap AB", "R7 defeated gap CD", "R2 phase no gap");

      // R10: independent legs
      dead_ab = 8'd4; dead_cd = 8'd10; phase_cmd = 6'd20;
      leg_case(5, 11, 26, "R10 leg AB gap", "R10 leg CD gap", "R10 phase with unequal gaps");

      // R2: zero phase and clamped maximum
      dead_ab = 8'd8; dead_cd = 8'd8; phase_cmd = 6'd0;
      leg_case(9, 9, 0, "R3 gap AB phase0", "R3 gap CD phase0", "R2 zero phase");
      phase_cmd = 6'd63;
      leg_case(9, 9, PERIOD - 1, "R3 gap AB max", "R3 gap CD max", "R2 phase clamp");

      // R6: current-limit pulse at tick 12 with phase 40
      phase_cmd = 6'd40;
      settle();
      sync_a();
      push(K_GAB, 9, "R6 gap AB");
      push(K_GCD, 9, "R6 gap CD");
      push(K_PH, 12, "R6 early swap on limit");
      repeat (11) @(negedge clk);
      ilim = 1'b1;
      @(negedge clk);
      ilim = 1'b0;
      drain();

      // R6: limit held high -> swap at cycle start
      ilim = 1'b1;
      leg_case(9, 9, 0, "R6 gap AB held", "R6 gap CD held", "R6 held limit");
      ilim = 1'b0;

      // R8: phase change inside a cycle waits for the next start
      phase_cmd = 6'd10;
      settle();
      sync_a();
      push(K_PH, 10, "R8 mid-cycle phase change ignored");
      phase_cmd = 6'd30;
      drain();
      leg_case(9, 9, 30, "R8 gap AB", "R8 gap CD", "R8 new phase next cycle");

      // R9: disable and restart
      @(negedge clk);
      en = 1'b0;
      repeat (5) @(negedge clk);
      check("R9 disabled outputs", {out_a, out_b, out_c, out_d, cycle_start}, 0);
      dead_ab = 8'd5;
      en = 1'b1;
      n = 0; gc = 0;
      @(negedge clk);
      while (!out_a && n < 200) begin
         if (out_b) gc++;
         n++;
         @(negedge clk);
      end
      check("R9 first A rise delay", n, 5 + 2);
      check("R9 B low before first A", gc, 0);

      // R3: overlap over the whole run
      check("R3 no overlap seen", int'(overlap_seen), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule